// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Register

This block gives software a small register window for sending interrupt messages to other processors. Software first writes the destination processor identifier into the high command word. It then writes the low command word, which holds the vector and the message attributes, and that write starts the message. The block copies the message into an outgoing holding register. It presents the message on a valid/accept/reject handshake and shows it as busy in the low word until the receiving side responds.

Problems are recorded in an error status register, with one sticky bit per cause. Three causes are detected here: a vector below the legal floor, a rejected message, and an access to an offset that is not decoded. Any write to the error status register clears it. Reading the register does not clear it.

The register offsets are word addresses on a single-access-per-cycle bus. The low command word is at offset 0, the high command word at offset 1 and the error status at offset 2. Every other offset is illegal.

Top module: `ipi_cmd_regs`

## Requirements
- R1: After reset, all three registers read 0 and `msg_valid` is 0.
- R2: Low-word readback layout: vector in bits 7:0, delivery mode in bits 10:8 (0 fixed, 1 lowest priority, 4 NMI, 5 INIT, 6 STARTUP, all eight codes stored), logical-destination flag in bit 11, busy flag in bit 12, assert level in bit 14, level-trigger flag in bit 15, shorthand in bits 19:18 (0 none, 1 self, 2 all including self, 3 all excluding self). All other low bits read 0. The high word returns the destination in bits 31:24 and 0 elsewhere.
- R3: A write to the low word while no message is busy, with a vector of 16 or more, raises `msg_valid` in the next cycle. The message carries the written fields and the high-word destination that held at the time of the write.
- R4: While a message is busy, low-word bit 12 reads 1. The outgoing message fields stay unchanged until it is accepted or rejected.
- R5: An `msg_ack` while `msg_valid` is high drops `msg_valid` in the next cycle, and low-word bit 12 then reads 0.
- R6: An `msg_nack` while `msg_valid` is high drops `msg_valid` in the next cycle and sets error bit 2 (send accept error).
- R7: A low-word write whose vector is below 16 sets error bit 5 (send illegal vector) and sends no message. The written fields are still stored and read back. A vector of exactly 16 is legal.
- R8: A low-word write while a message is busy is ignored: neither the stored low word nor the outgoing message changes.
- R9: A high-word write while a message is busy updates the stored destination but not the outgoing message's destination.
- R10: A read or write at any offset other than 0, 1 or 2 sets error bit 7 (illegal register address), reads 0 and changes no other register.
- R11: A write of any value to the error status register clears all error bits. An error raised in the same cycle as the clear stays set. Only bits 2, 5 and 7 can become 1.
- R12: Reading the error status register does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Word offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the access |
| msg_valid | output | 1 | Outgoing message is busy / presented |
| msg_vector | output | 8 | Message vector |
| msg_mode | output | 3 | Delivery mode |
| msg_logical | output | 1 | Logical (1) or physical (0) destination |
| msg_assert | output | 1 | Level: assert (1) or deassert (0) |
| msg_level_trig | output | 1 | Level (1) or edge (0) trigger |
| msg_shorthand | output | 2 | Destination shorthand |
| msg_dest | output | 8 | Destination processor identifier |
| msg_ack | input | 1 | Receiver accepted the message |
| msg_nack | input | 1 | Receiver rejected the message |

## Verification
The assertions assume the receiving side follows the handshake. `msg_ack` and `msg_nack` pulse only while `msg_valid` is high, and never together. A handshake-legality assertion checks this assumption. The bench drives each response as a single-cycle pulse, issued only after it has seen `msg_valid` high. It makes exactly one register access per cycle, so register writes and the error clear can meet a handshake response in the same cycle but never meet one another.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    localparam int DEST_W = 8;
    localparam int ESR_W  = 8;

    // Error status bit positions (software decodes these)
    localparam int ESR_SEND_CSUM  = 0;
    localparam int ESR_RECV_CSUM  = 1;
    localparam int ESR_SEND_ACC   = 2;
    localparam int ESR_RECV_ACC   = 3;
    localparam int ESR_SEND_ILLV  = 5;
    localparam int ESR_RECV_ILLV  = 6;
    localparam int ESR_ILL_ADDR   = 7;

    // Delivery mode codes
    localparam logic [2:0] DM_FIXED   = 3'd0;
    localparam logic [2:0] DM_LOWEST  = 3'd1;
    localparam logic [2:0] DM_NMI     = 3'd4;
    localparam logic [2:0] DM_INIT    = 3'd5;
    localparam logic [2:0] DM_STARTUP = 3'd6;

    // Shorthand codes
    localparam logic [1:0] SH_NONE     = 2'd0;
    localparam logic [1:0] SH_SELF     = 2'd1;
    localparam logic [1:0] SH_ALL_INCL = 2'd2;
    localparam logic [1:0] SH_ALL_EXCL = 2'd3;

    typedef struct packed {
        logic [1:0] shorthand;
        logic       level_trig;
        logic       assert_lvl;
        logic       logical;
        logic [2:0] mode;
        logic [7:0] vector;
    } cmd_fields_t;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        cmd_fields_t       fields;
    } ipi_msg_t;

    function automatic cmd_fields_t unpack_low(input logic [31:0] w);
        cmd_fields_t f;
        f.vector     = w[7:0];
        f.mode       = w[10:8];
        f.logical    = w[11];
        f.assert_lvl = w[14];
        f.level_trig = w[15];
        f.shorthand  = w[19:18];
        return f;
    endfunction

    function automatic logic [31:0] pack_low(input cmd_fields_t f, input logic busy);
        logic [31:0] w;
        w        = '0;
        w[7:0]   = f.vector;
        w[10:8]  = f.mode;
        w[11]    = f.logical;
        w[12]    = busy;
        w[14]    = f.assert_lvl;
        w[15]    = f.level_trig;
        w[19:18] = f.shorthand;
        return w;
    endfunction

endpackage

// File: rtl/ipi_reg_decode.sv
module ipi_reg_decode #(
    parameter int ADDR_W = 4,
    parameter int OFF_LO  = 0,
    parameter int OFF_HI  = 1,
    parameter int OFF_ERR = 2
) (
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_lo,
    output logic              hit_hi,
    output logic              hit_err,
    output logic              wr_lo,
    output logic              wr_hi,
    output logic              wr_err,
    output logic              bad_access
);

    localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(OFF_LO);
    localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(OFF_HI);
    localparam logic [ADDR_W-1:0] A_ERR = ADDR_W'(OFF_ERR);

    always_comb begin
        hit_lo     = en && (addr == A_LO);
        hit_hi     = en && (addr == A_HI);
        hit_err    = en && (addr == A_ERR);
        wr_lo      = hit_lo  && we;
        wr_hi      = hit_hi  && we;
        wr_err     = hit_err && we;
        bad_access = en && !(hit_lo || hit_hi || hit_err);
    end

endmodule

// File: rtl/ipi_launch.sv
module ipi_launch
    import ipi_pkg::*;
#(
    parameter int MIN_VECTOR = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    input  logic        ack,
    input  logic        nack,
    output cmd_fields_t low_q,
    output logic [DEST_W-1:0] dest_q,
    output logic        busy_q,
    output ipi_msg_t    msg_q,
    output logic        illegal_vec,
    output logic        rejected
);

    localparam logic [7:0] VEC_FLOOR = 8'(MIN_VECTOR);

    typedef struct packed {
        cmd_fields_t       low;
        logic [DEST_W-1:0] dest;
        logic              busy;
        ipi_msg_t          msg;
    } launch_state_t;

    launch_state_t st_d, st_q;
    cmd_fields_t   wfields;
    logic          unused_wbits;

    assign unused_wbits = ^{wdata[23:20], wdata[17:16], wdata[13:12]};

    always_comb begin
        st_d        = st_q;
        wfields     = unpack_low(wdata);
        illegal_vec = wr_lo && !st_q.busy && (wfields.vector < VEC_FLOOR);
        rejected    = st_q.busy && nack;

        if (wr_hi) begin
            st_d.dest = wdata[31:24];
        end

        if (wr_lo && !st_q.busy) begin
            st_d.low = wfields;
            if (!illegal_vec) begin
                st_d.busy       = 1'b1;
                st_d.msg.fields = wfields;
                st_d.msg.dest   = st_q.dest;
            end
        end

        if (st_q.busy && (ack || nack)) begin
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign low_q  = st_q.low;
    assign dest_q = st_q.dest;
    assign busy_q = st_q.busy;
    assign msg_q  = st_q.msg;

endmodule

// File: rtl/ipi_err_latch.sv
module ipi_err_latch
    import ipi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ESR_W-1:0] set_bits,
    input  logic             clr,
    output logic [ESR_W-1:0] esr_q
);

    typedef struct packed {
        logic [ESR_W-1:0] bits;
    } err_state_t;

    err_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.bits = '0;
        end
        // A cause arriving with the clear survives it
        st_d.bits = st_d.bits | set_bits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign esr_q = st_q.bits;

endmodule

// File: rtl/ipi_cmd_regs.sv
module ipi_cmd_regs
    import ipi_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int OFF_LO     = 0,
    parameter int OFF_HI     = 1,
    parameter int OFF_ERR    = 2,
    parameter int MIN_VECTOR = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              msg_valid,
    output logic [7:0]        msg_vector,
    output logic [2:0]        msg_mode,
    output logic              msg_logical,
    output logic              msg_assert,
    output logic              msg_level_trig,
    output logic [1:0]        msg_shorthand,
    output logic [7:0]        msg_dest,
    input  logic              msg_ack,
    input  logic              msg_nack
);

    logic hit_lo, hit_hi, hit_err;
    logic wr_lo, wr_hi, wr_err, bad_access;

    cmd_fields_t       low_q;
    logic [DEST_W-1:0] dest_q;
    logic              busy_q;
    ipi_msg_t          msg_q;
    logic              illegal_vec, rejected;

    logic [ESR_W-1:0]  err_set;
    logic [ESR_W-1:0]  esr_q;

    ipi_reg_decode #(
        .ADDR_W (ADDR_W),
        .OFF_LO (OFF_LO),
        .OFF_HI (OFF_HI),
        .OFF_ERR(OFF_ERR)
    ) u_decode (
        .en        (reg_en),
        .we        (reg_we),
        .addr      (reg_addr),
        .hit_lo    (hit_lo),
        .hit_hi    (hit_hi),
        .hit_err   (hit_err),
        .wr_lo     (wr_lo),
        .wr_hi     (wr_hi),
        .wr_err    (wr_err),
        .bad_access(bad_access)
    );

    ipi_launch #(
        .MIN_VECTOR(MIN_VECTOR)
    ) u_launch (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_lo      (wr_lo),
        .wr_hi      (wr_hi),
        .wdata      (reg_wdata),
        .ack        (msg_ack),
        .nack       (msg_nack),
        .low_q      (low_q),
        .dest_q     (dest_q),
        .busy_q     (busy_q),
        .msg_q      (msg_q),
        .illegal_vec(illegal_vec),
        .rejected   (rejected)
    );

    always_comb begin
        err_set                = '0;
        err_set[ESR_SEND_ACC]  = rejected;
        err_set[ESR_SEND_ILLV] = illegal_vec;
        err_set[ESR_ILL_ADDR]  = bad_access;
    end

    ipi_err_latch u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_bits(err_set),
        .clr     (wr_err),
        .esr_q   (esr_q)
    );

    always_comb begin
        reg_rdata = '0;
        if (hit_lo) begin
            reg_rdata = pack_low(low_q, busy_q);
        end else if (hit_hi) begin
            reg_rdata[31:24] = dest_q;
        end else if (hit_err) begin
            reg_rdata[ESR_W-1:0] = esr_q;
        end
    end

    assign msg_valid      = busy_q;
    assign msg_vector     = msg_q.fields.vector;
    assign msg_mode       = msg_q.fields.mode;
    assign msg_logical    = msg_q.fields.logical;
    assign msg_assert     = msg_q.fields.assert_lvl;
    assign msg_level_trig = msg_q.fields.level_trig;
    assign msg_shorthand  = msg_q.fields.shorthand;
    assign msg_dest       = msg_q.dest;

endmodule

// File: rtl/ipi_cmd_regs_chk.sv
module ipi_cmd_regs_chk #(
    parameter int ADDR_W     = 4,
    parameter int OFF_LO     = 0,
    parameter int OFF_ERR    = 2,
    parameter int OFF_HI     = 1,
    parameter int MIN_VECTOR = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_en,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              msg_valid,
    input logic [7:0]        msg_vector,
    input logic [2:0]        msg_mode,
    input logic [7:0]        msg_dest,
    input logic              msg_ack,
    input logic              msg_nack,
    input logic [7:0]        esr
);

    localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(OFF_LO);
    localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(OFF_HI);
    localparam logic [ADDR_W-1:0] A_ERR = ADDR_W'(OFF_ERR);
    localparam logic [7:0]        VFL   = 8'(MIN_VECTOR);

    logic low_wr, err_wr, bad;
    assign low_wr = reg_en && reg_we && (reg_addr == A_LO);
    assign err_wr = reg_en && reg_we && (reg_addr == A_ERR);
    assign bad    = reg_en && (reg_addr != A_LO) && (reg_addr != A_HI) && (reg_addr != A_ERR);

    // Handshake assumption (R5, R6)
    assert_handshake_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_ack || msg_nack) |-> (msg_valid && !(msg_ack && msg_nack)));

    assert_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (low_wr && !msg_valid && reg_wdata[7:0] >= VFL) |=> (msg_valid && msg_vector == $past(reg_wdata[7:0])));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ack && !msg_nack) |=>
        (msg_valid && $stable(msg_vector) && $stable(msg_mode) && $stable(msg_dest)));

    assert_ack_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ack) |=> !msg_valid);

    assert_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_nack) |=> (!msg_valid && esr[2]));

    assert_low_vector_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (low_wr && !msg_valid && reg_wdata[7:0] < VFL) |=> (!msg_valid && esr[5]));

    assert_bad_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bad |=> esr[7]);

    assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (err_wr && !msg_nack) |=> (esr == 8'h00));

    assert_bits_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (esr & 8'h5B) == 8'h00);

endmodule

bind ipi_cmd_regs ipi_cmd_regs_chk #(
    .ADDR_W    (ADDR_W),
    .OFF_LO    (OFF_LO),
    .OFF_HI    (OFF_HI),
    .OFF_ERR   (OFF_ERR),
    .MIN_VECTOR(MIN_VECTOR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_en    (reg_en),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .msg_valid (msg_valid),
    .msg_vector(msg_vector),
    .msg_mode  (msg_mode),
    .msg_dest  (msg_dest),
    .msg_ack   (msg_ack),
    .msg_nack  (msg_nack),
    .esr       (esr_q)
);

// File: tb/ipi_cmd_regs_test.sv
module ipi_cmd_regs_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        msg_valid;
    logic [7:0]  msg_vector;
    logic [2:0]  msg_mode;
    logic        msg_logical, msg_assert, msg_level_trig;
    logic [1:0]  msg_shorthand;
    logic [7:0]  msg_dest;
    logic        msg_ack = 1'b0;
    logic        msg_nack = 1'b0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ipi_cmd_regs uut (
        .clk(clk), .rst_n(rst_n),
        .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .msg_valid(msg_valid), .msg_vector(msg_vector), .msg_mode(msg_mode),
        .msg_logical(msg_logical), .msg_assert(msg_assert),
        .msg_level_trig(msg_level_trig), .msg_shorthand(msg_shorthand),
        .msg_dest(msg_dest), .msg_ack(msg_ack), .msg_nack(msg_nack)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_en = 1'b0;
    endtask

    task automatic respond(input logic accept);
        @(negedge clk);
        if (accept) msg_ack = 1'b1; else msg_nack = 1'b1;
        @(negedge clk);
        msg_ack = 1'b0; msg_nack = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(4'd0, d); check("R1 low", d, 32'h0);
        rd(4'd1, d); check("R1 high", d, 32'h0);
        rd(4'd2, d); check("R1 esr", d, 32'h0);
        check("R1 valid", 32'(msg_valid), 32'h0);
    endtask

    task automatic t_launch_accept;
        logic [31:0] d;
        wr(4'd1, 32'hAB123456);
        rd(4'd1, d); check("R2 high layout", d, 32'hAB000000);
        wr(4'd0, 32'hFFFFFFFF);
        check("R3 valid", 32'(msg_valid), 32'h1);
        check("R3 fields", {msg_vector, 5'b0, msg_mode, msg_logical, msg_assert,
                            msg_level_trig, msg_shorthand, 3'b0},
              {8'hFF, 5'b0, 3'h7, 1'b1, 1'b1, 1'b1, 2'h3, 3'b0});
        check("R3 dest", 32'(msg_dest), 32'hAB);
        rd(4'd0, d); check("R2 R4 low layout busy", d, 32'h000CDFFF);
        repeat (3) @(negedge clk);
        check("R4 still valid", 32'(msg_valid), 32'h1);
        check("R4 vector held", 32'(msg_vector), 32'hFF);
        wr(4'd0, 32'h00000050);
        rd(4'd0, d); check("R8 low unchanged", d, 32'h000CDFFF);
        check("R8 msg unchanged", 32'(msg_vector), 32'hFF);
        wr(4'd1, 32'h12000000);
        rd(4'd1, d); check("R9 high updated", d, 32'h12000000);
        check("R9 msg dest held", 32'(msg_dest), 32'hAB);
        respond(1'b1);
        check("R5 valid dropped", 32'(msg_valid), 32'h0);
        rd(4'd0, d); check("R5 busy bit clear", d, 32'h000CCFFF);
        rd(4'd2, d); check("R5 no error", d, 32'h0);
    endtask

    task automatic t_reject;
        logic [31:0] d;
        wr(4'd0, 32'h00004520);
        check("R3 INIT mode", 32'(msg_mode), 32'h5);
        check("R3 new dest", 32'(msg_dest), 32'h12);
        respond(1'b0);
        check("R6 valid dropped", 32'(msg_valid), 32'h0);
        rd(4'd2, d); check("R6 accept error", d, 32'h04);
        rd(4'd2, d); check("R12 read keeps esr", d, 32'h04);
        wr(4'd2, 32'h0);
        rd(4'd2, d); check("R11 cleared", d, 32'h0);
    endtask

    task automatic t_illegal_vector;
        logic [31:0] d;
        wr(4'd0, 32'h0000000F);
        check("R7 no message", 32'(msg_valid), 32'h0);
        repeat (2) @(negedge clk);
        check("R7 still no message", 32'(msg_valid), 32'h0);
        rd(4'd2, d); check("R7 illegal vector bit", d, 32'h20);
        rd(4'd0, d); check("R7 fields stored", d, 32'h0000000F);
        wr(4'd2, 32'hFFFFFFFF);
        wr(4'd0, 32'h00000010);
        check("R7 floor vector launches", 32'(msg_valid), 32'h1);
        respond(1'b1);
        rd(4'd2, d); check("R7 floor no error", d, 32'h0);
    endtask

    task automatic t_bad_address;
        logic [31:0] d;
        rd(4'd7, d); check("R10 read data zero", d, 32'h0);
        rd(4'd2, d); check("R10 read sets bit", d, 32'h80);
        wr(4'd2, 32'h5A5A5A5A);
        wr(4'd15, 32'hFFFFFFFF);
        rd(4'd2, d); check("R10 write sets bit", d, 32'h80);
        rd(4'd0, d); check("R10 low untouched", d, 32'h00000010);
        rd(4'd1, d); check("R10 high untouched", d, 32'h12000000);
        check("R10 no message", 32'(msg_valid), 32'h0);
        wr(4'd2, 32'hFFFFFFFF);
        rd(4'd2, d); check("R11 any value clears", d, 32'h0);
    endtask

    task automatic t_clear_race;
        logic [31:0] d;
        wr(4'd0, 32'h00000040);
        check("R3 launch", 32'(msg_valid), 32'h1);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = 4'd2; reg_wdata = 32'h0;
        msg_nack = 1'b1;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0; msg_nack = 1'b0;
        rd(4'd2, d); check("R11 set beats clear", d, 32'h04);
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_launch_accept();
        t_reject();
        t_illegal_vector();
        t_bad_address();
        t_clear_race();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule